// File: doc/BRIEF.md
# Interrupt Acknowledge Pin Stretcher

The block turns a single-cycle acknowledge strobe and its interrupt number, both produced in the fast processor clock domain, into a pin waveform that a slower board-level observer can sample reliably. The output clock runs at half the processor rate and is derived from it, so its rising edges coincide with every second processor edge. A strobe that falls between two output-clock edges is still latched in the processor domain and then turned into a full frame on the output side.

Each frame lasts four output-clock cycles. The number pins carry the latched interrupt number for the whole frame. The acknowledge pin is held low in the first cycle (setup), high for the next two, and low again in the last one (hold). The number pins go back to zero once the frame ends. A `busy` flag is high from the latched strobe to the end of the frame. Any strobe that arrives while `busy` is high is discarded: it is neither queued nor allowed to disturb the frame being driven.

Top module: `irq_ack_stretcher`

## Requirements
- R1: While reset is asserted, `ack_pin` is low, `num_pin` is zero and `busy` is low, and this holds even if reset arrives in the middle of a frame.
- R2: A strobe latched at a processor edge starts a frame at the first output-clock rising edge after that edge. In the first frame cycle `num_pin` carries the latched number and `ack_pin` is still low.
- R3: `ack_pin` is high for exactly two consecutive output-clock cycles per frame, in frame cycles two and three, and it changes only at output-clock rising edges.
- R4: `num_pin` holds the latched number unchanged for all four frame cycles, including the hold cycle after `ack_pin` falls.
- R5: A strobe that is high only at a processor edge falling between output-clock edges produces the same full frame as one that is high at an output-clock edge.
- R6: A strobe that arrives while `busy` is high is dropped. It does not change the number or timing of the current frame, and no second frame follows.
- R7: `busy` goes high at the processor edge that latches a strobe and goes low at the output-clock edge that ends the frame.
- R8: A strobe latched at the first processor edge after `busy` falls is accepted and starts a new, complete frame.
- R9: Outside a frame, `ack_pin` is low and `num_pin` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | Fast processor clock |
| out_clk | input | 1 | Output clock at half the processor rate, rising with every second processor rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| int_ack | input | 1 | Single-cycle acknowledge strobe, processor domain |
| int_num | input | NUM_W | Interrupt number that goes with the strobe |
| ack_pin | output | 1 | Stretched acknowledge, active high with the default polarity |
| num_pin | output | NUM_W | Interrupt number framing the acknowledge, zero when idle |
| busy | output | 1 | A frame is pending or being driven |

## Verification
Strobes are sent both on processor edges that coincide with an output-clock edge and on the edges between them. The two cases must give identical frames that start one output cycle apart, which separates correct capture from plain sampling on the slow clock. The numbers tried include all-zeros, all-ones and mixed patterns, so a stuck or shifted number bit shows up against the expected frame. Strobes are also sent while a frame is pending, while it is being driven, and at the first cycle after `busy` clears. These cases separate dropping from queueing and check the exact re-arm point.

// File: rtl/ackx_pkg.sv
package ackx_pkg;
   typedef enum logic {
      POL_LOW  = 1'b0,
      POL_HIGH = 1'b1
   } pin_pol_e;

   function automatic int phase_bits(input int frame_len);
      return $clog2(frame_len + 1);
   endfunction
endpackage

// File: rtl/ackx_capture.sv
module ackx_capture #(
   parameter int NUM_W = 5
) (
   input  logic             cpu_clk,
   input  logic             rst_n,
   input  logic             ack_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic             frame_on_i,
   output logic             pending_o,
   output logic [NUM_W-1:0] num_hold_o,
   output logic             busy_o
);
   logic             pend_q;
   logic [NUM_W-1:0] hold_q;
   logic             accept;

   assign busy_o     = pend_q | frame_on_i;
   assign accept     = ack_i & ~busy_o;
   assign pending_o  = pend_q;
   assign num_hold_o = hold_q;

   always_ff @(posedge cpu_clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         hold_q <= '0;
      end else if (accept) begin
         pend_q <= 1'b1;
         hold_q <= num_i;
      end else if (frame_on_i) begin
         pend_q <= 1'b0;
      end
   end

   // R6: a strobe arriving while busy must leave the latched number alone
   assert_drop_keeps_num_R6: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (ack_i && busy_o) |=> $stable(num_hold_o));

   // R7: an accepted strobe raises busy at the next processor cycle
   assert_busy_after_accept_R7: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (ack_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/ackx_sequencer.sv
module ackx_sequencer #(
   parameter int SETUP_CYC = 1,
   parameter int ACK_CYC   = 2,
   parameter int HOLD_CYC  = 1,
   localparam int FRAME_LEN = SETUP_CYC + ACK_CYC + HOLD_CYC,
   localparam int PH_W      = ackx_pkg::phase_bits(FRAME_LEN)
) (
   input  logic            out_clk,
   input  logic            rst_n,
   input  logic            start_i,
   output logic [PH_W-1:0] nxt_ph_o,
   output logic            frame_on_o
);
   localparam logic [PH_W-1:0] PH_IDLE = '0;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_LEN);

   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] ph_d;

   always_comb begin
      if (ph_q == PH_IDLE) begin
         ph_d = start_i ? PH_W'(1) : PH_IDLE;
      end else if (ph_q == PH_LAST) begin
         ph_d = PH_IDLE;
      end else begin
         ph_d = ph_q + PH_W'(1);
      end
   end

   always_ff @(posedge out_clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign nxt_ph_o   = ph_d;
   assign frame_on_o = (ph_q != PH_IDLE);

   // R2: a pending strobe seen while idle must open a frame at this edge
   assert_start_opens_frame_R2: assert property (@(posedge out_clk) disable iff (!rst_n)
      (!frame_on_o && start_i) |=> frame_on_o);
endmodule

// File: rtl/ackx_pin_drive.sv
module ackx_pin_drive #(
   parameter int                NUM_W     = 5,
   parameter int                SETUP_CYC = 1,
   parameter int                ACK_CYC   = 2,
   parameter int                HOLD_CYC  = 1,
   parameter ackx_pkg::pin_pol_e ACK_POL  = ackx_pkg::POL_HIGH,
   parameter logic [NUM_W-1:0]  IDLE_NUM  = '0,
   localparam int FRAME_LEN = SETUP_CYC + ACK_CYC + HOLD_CYC,
   localparam int PH_W      = ackx_pkg::phase_bits(FRAME_LEN)
) (
   input  logic             out_clk,
   input  logic             rst_n,
   input  logic [PH_W-1:0]  nxt_ph_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic             frame_on_i,
   output logic             ack_pin_o,
   output logic [NUM_W-1:0] num_pin_o
);
   localparam logic [PH_W-1:0] ACK_FIRST = PH_W'(SETUP_CYC + 1);
   localparam logic [PH_W-1:0] ACK_LAST  = PH_W'(SETUP_CYC + ACK_CYC);

   logic             ack_q;
   logic [NUM_W-1:0] num_q;
   logic             ack_d;

   assign ack_d = (nxt_ph_i >= ACK_FIRST) && (nxt_ph_i <= ACK_LAST);

   always_ff @(posedge out_clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         num_q <= IDLE_NUM;
      end else begin
         ack_q <= ack_d;
         num_q <= (nxt_ph_i != '0) ? num_i : IDLE_NUM;
      end
   end

   generate
      if (ACK_POL == ackx_pkg::POL_HIGH) begin : g_pol_high
         assign ack_pin_o = ack_q;
      end else begin : g_pol_low
         assign ack_pin_o = ~ack_q;
      end
   endgenerate

   assign num_pin_o = num_q;

   // checker state: length of the current acknowledge run
   logic [PH_W-1:0] run_len;
   always_ff @(posedge out_clk or negedge rst_n) begin
      if (!rst_n)     run_len <= '0;
      else if (ack_q) run_len <= run_len + PH_W'(1);
      else            run_len <= '0;
   end

   // R3: acknowledge never runs longer than its configured width
   assert_ack_not_long_R3: assert property (@(posedge out_clk) disable iff (!rst_n)
      ack_q |-> (run_len < PH_W'(ACK_CYC)));

   // R3: acknowledge drops only after its full width
   assert_ack_full_width_R3: assert property (@(posedge out_clk) disable iff (!rst_n)
      $fell(ack_q) |-> (run_len == PH_W'(ACK_CYC)));

   // R4: number is steady while acknowledge is high and through the hold cycle
   assert_num_steady_R4: assert property (@(posedge out_clk) disable iff (!rst_n)
      (ack_q || $fell(ack_q)) |-> $stable(num_q));

   // R9: outside a frame the pins sit idle
   assert_idle_quiet_R9: assert property (@(posedge out_clk) disable iff (!rst_n)
      !frame_on_i |-> (!ack_q && num_q == IDLE_NUM));
endmodule

// File: rtl/irq_ack_stretcher.sv
module irq_ack_stretcher #(
   parameter int                NUM_W     = 5,
   parameter int                SETUP_CYC = 1,
   parameter int                ACK_CYC   = 2,
   parameter int                HOLD_CYC  = 1,
   parameter ackx_pkg::pin_pol_e ACK_POL  = ackx_pkg::POL_HIGH,
   parameter logic [NUM_W-1:0]  IDLE_NUM  = '0
) (
   input  logic             cpu_clk,
   input  logic             out_clk,
   input  logic             rst_n,
   input  logic             int_ack,
   input  logic [NUM_W-1:0] int_num,
   output logic             ack_pin,
   output logic [NUM_W-1:0] num_pin,
   output logic             busy
);
   localparam int FRAME_LEN = SETUP_CYC + ACK_CYC + HOLD_CYC;
   localparam int PH_W      = ackx_pkg::phase_bits(FRAME_LEN);

   generate
      if (NUM_W < 1) begin : g_bad_num_w
         $error("NUM_W must be at least 1");
      end
      if (SETUP_CYC < 1 || HOLD_CYC < 1) begin : g_bad_margin
         $error("setup and hold margins must each be at least one cycle");
      end
      if (ACK_CYC < 1) begin : g_bad_ack
         $error("ACK_CYC must be at least 1");
      end
   endgenerate

   logic             pending;
   logic             frame_on;
   logic [NUM_W-1:0] num_hold;
   logic [PH_W-1:0]  nxt_ph;

   ackx_capture #(.NUM_W(NUM_W)) u_capture (
      .cpu_clk    (cpu_clk),
      .rst_n      (rst_n),
      .ack_i      (int_ack),
      .num_i      (int_num),
      .frame_on_i (frame_on),
      .pending_o  (pending),
      .num_hold_o (num_hold),
      .busy_o     (busy)
   );

   ackx_sequencer #(
      .SETUP_CYC (SETUP_CYC),
      .ACK_CYC   (ACK_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) u_sequencer (
      .out_clk    (out_clk),
      .rst_n      (rst_n),
      .start_i    (pending),
      .nxt_ph_o   (nxt_ph),
      .frame_on_o (frame_on)
   );

   ackx_pin_drive #(
      .NUM_W     (NUM_W),
      .SETUP_CYC (SETUP_CYC),
      .ACK_CYC   (ACK_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .ACK_POL   (ACK_POL),
      .IDLE_NUM  (IDLE_NUM)
   ) u_pins (
      .out_clk    (out_clk),
      .rst_n      (rst_n),
      .nxt_ph_i   (nxt_ph),
      .num_i      (num_hold),
      .frame_on_i (frame_on),
      .ack_pin_o  (ack_pin),
      .num_pin_o  (num_pin)
   );
endmodule

// File: tb/test_irq_ack_stretcher.sv
module test_irq_ack_stretcher;
   localparam int NUM_W = 5;

   logic             cpu_clk = 1'b0;
   logic             out_clk = 1'b0;
   logic             rst_n   = 1'b0;
   logic             int_ack = 1'b0;
   logic [NUM_W-1:0] int_num = '0;
   logic             ack_pin;
   logic [NUM_W-1:0] num_pin;
   logic             busy;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   irq_ack_stretcher #(.NUM_W(NUM_W)) i_irq_ack_stretcher (
      .cpu_clk (cpu_clk),
      .out_clk (out_clk),
      .rst_n   (rst_n),
      .int_ack (int_ack),
      .int_num (int_num),
      .ack_pin (ack_pin),
      .num_pin (num_pin),
      .busy    (busy)
   );

   // 100 MHz processor clock; output clock at half rate, both edges set together
   initial begin
      forever begin
         #5;
         cpu_clk = ~cpu_clk;
         if (cpu_clk) out_clk = ~out_clk;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // bit 5: strobe on the processor edge that coincides with an output edge
   localparam logic [5:0] VEC [6] = '{6'h03, 6'h25, 6'h00, 6'h3F, 6'h1A, 6'h31};

   // strobe for one processor cycle; off=1 lands it on an output-clock edge
   task automatic send(input bit off, input logic [NUM_W-1:0] n);
      @(posedge out_clk);
      if (off) @(posedge cpu_clk);
      #1 int_ack = 1'b1; int_num = n;
      @(posedge cpu_clk);
      #1 int_ack = 1'b0; int_num = ~n;
      #1 check("R7", "busy after strobe", int'(busy), 1);
   endtask

   // frame starts at the first output edge after the latching processor edge
   task automatic expect_frame(input logic [NUM_W-1:0] n, input string req);
      @(posedge out_clk); #2;
      check("R2", {req, " setup num"}, int'(num_pin), int'(n));
      check("R2", {req, " setup ack low"}, int'(ack_pin), 0);
      for (int k = 0; k < 2; k++) begin
         @(posedge out_clk); #2;
         check("R3", {req, " ack high"}, int'(ack_pin), 1);
         check("R4", {req, " num during ack"}, int'(num_pin), int'(n));
      end
      @(posedge out_clk); #2;
      check("R3", {req, " ack low in hold"}, int'(ack_pin), 0);
      check("R4", {req, " num in hold"}, int'(num_pin), int'(n));
      check("R7", {req, " busy in hold"}, int'(busy), 1);
      @(posedge out_clk); #2;
      check("R9", {req, " idle num"}, int'(num_pin), 0);
      check("R9", {req, " idle ack"}, int'(ack_pin), 0);
      check("R7", {req, " busy cleared"}, int'(busy), 0);
   endtask

   initial begin
      #22;
      check("R1", "reset ack", int'(ack_pin), 0);
      check("R1", "reset num", int'(num_pin), 0);
      check("R1", "reset busy", int'(busy), 0);
      @(negedge cpu_clk) rst_n = 1'b1;

      // table walk: both capture alignments, varied numbers (R5 for off=0 cases)
      for (int i = 0; i < 6; i++) begin
         send(VEC[i][5], VEC[i][4:0]);
         expect_frame(VEC[i][4:0], VEC[i][5] ? "R2 aligned" : "R5 between edges");
      end

      // R6: strobe while still pending (aligned capture leaves one spare cycle)
      send(1'b1, 5'h0B);
      #1 int_ack = 1'b1; int_num = 5'h14;
      @(posedge cpu_clk);
      #1 int_ack = 1'b0;
      expect_frame(5'h0B, "R6 pending drop");
      for (int k = 0; k < 5; k++) begin
         @(posedge out_clk); #2;
         check("R6", "no follow-on ack", int'(ack_pin), 0);
         check("R6", "no follow-on num", int'(num_pin), 0);
      end

      // R6: strobe in the middle of an active frame
      send(1'b0, 5'h06);
      @(posedge out_clk); #2;
      check("R2", "mid-drop setup num", int'(num_pin), 6);
      int_ack = 1'b1; int_num = 5'h19;
      @(posedge cpu_clk);
      #1 int_ack = 1'b0;
      for (int k = 0; k < 2; k++) begin
         @(posedge out_clk); #2;
         check("R6", "active drop ack", int'(ack_pin), 1);
         check("R6", "active drop num", int'(num_pin), 6);
      end
      @(posedge out_clk); #2;
      check("R6", "active drop hold num", int'(num_pin), 6);
      for (int k = 0; k < 4; k++) begin
         @(posedge out_clk); #2;
         check("R6", "no second frame", int'(num_pin), 0);
         check("R6", "no second ack", int'(ack_pin), 0);
      end

      // R8: strobe latched at the first processor edge after busy falls
      send(1'b0, 5'h11);
      expect_frame(5'h11, "R8 first");
      int_ack = 1'b1; int_num = 5'h0E;
      @(posedge cpu_clk);
      #1 int_ack = 1'b0;
      check("R8", "busy on re-arm", int'(busy), 1);
      expect_frame(5'h0E, "R8 back-to-back");

      // R1: reset in the middle of a frame clears pins at once
      send(1'b0, 5'h1F);
      @(posedge out_clk);
      @(posedge out_clk); #3;
      check("R3", "ack before reset", int'(ack_pin), 1);
      rst_n = 1'b0;
      #1;
      check("R1", "mid reset ack", int'(ack_pin), 0);
      check("R1", "mid reset num", int'(num_pin), 0);
      check("R1", "mid reset busy", int'(busy), 0);
      @(negedge cpu_clk) rst_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(posedge out_clk); #2;
         check("R1", "quiet after reset", int'(ack_pin), 0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule